// File: doc/BRIEF.md
# Banked Byte Memory with Address Decode

This block is the memory side of a small processor bus. Four 128-byte read/write banks and one 512-byte read-only bank sit behind one 16-bit address bus and one 8-bit data bus. The processor presents an address together with a read strobe or a write strobe. A fixed decoder turns the address into chip selects, so that exactly one bank is addressed at a time. Every bank has two selects: one is active high and one is active low. A bank acts only when both selects are asserted and exactly one of the two strobes is high.

The shared data bus would be three-state on a board. Here it is modelled by a drive flag and a data byte that is forced to zero whenever the flag is low. Writes are taken on the rising clock edge. A read strobe seen on one rising edge returns its byte, with the drive flag high, from that edge until the next one, so reads have one cycle of latency. The read-only bank is filled at start-up from a fixed formula set by parameters. The reset is synchronous and active high. It clears the returned data and the drive flag, and it does not clear the stored bytes.

Top module: `bytebank_top`

## Requirements
- R1: While reset is high at a rising edge, `bus_drive` is 0 and `bus_rdata` is 0 after that edge, even when a read strobe is present.
- R2: A cycle with `bus_wr`=1, `bus_rd`=0 and address bit 9 (0-based) clear stores `bus_wdata` in RAM bank `bus_addr[8:7]` at offset `bus_addr[6:0]`. The following cycle shows `bus_drive`=0 and `bus_rdata`=0.
- R3: A cycle with `bus_rd`=1 and `bus_wr`=0 makes the next cycle show `bus_drive`=1 and the addressed byte on `bus_rdata`.
- R4: The four RAM banks are distinct. The same offset in different banks holds independent bytes, and within a bank all 128 offsets are independent.
- R5: When address bit 9 is set, a read returns the ROM byte at offset k = `bus_addr[8:0]`. That byte is the low 8 bits of ((29*k + 91) XOR (k >> 1)).
- R6: A write with address bit 9 set changes no RAM byte and no ROM byte.
- R7: When `bus_rd` and `bus_wr` are both high, nothing is stored and the next cycle shows `bus_drive`=0.
- R8: When both strobes are low, the next cycle shows `bus_drive`=0.
- R9: Address bits 15 down to 10 have no effect on reads or writes.
- R10: Whenever `bus_drive` is 0, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte address; bits 9..0 decoded |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not driven |
| bus_drive | output | 1 | High for the cycle after a valid read |

## Verification
A corrupted RAM byte does not appear at the ports until that exact bank and offset is read. It then shows one cycle after the read strobe, so the bench reads back every location it writes. A decode fault that merges two banks only shows up as aliasing, so the bench writes the same offset in all four banks with different values before reading any of them back. A stuck bank valid register shows as `bus_drive` high on the first idle cycle. For that reason every idle, write and inhibited cycle is also checked against a drive flag of 0 and data of 0.

// File: rtl/bbk_pkg.sv
`timescale 1ns/1ps
package bbk_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_RD    = 2'd1,
    ACC_WR    = 2'd2,
    ACC_CLASH = 2'd3
  } acc_e;

  // Two-select truth table: act only with sel_hi=1 and sel_lo_n=0,
  // and only when exactly one strobe is high.
  function automatic acc_e access_kind(input logic sel_hi, input logic sel_lo_n,
                                       input logic rd, input logic wr);
    if (!(sel_hi && !sel_lo_n)) return ACC_NONE;
    case ({rd, wr})
      2'b10:   return ACC_RD;
      2'b01:   return ACC_WR;
      2'b11:   return ACC_CLASH;
      default: return ACC_NONE;
    endcase
  endfunction

  // Start-up image generator for the read-only bank.
  function automatic logic [31:0] rom_word(input int unsigned k, input int unsigned mul,
                                           input int unsigned add);
    int unsigned t;
    t = (k * mul + add) ^ (k >> 1);
    return 32'(t);
  endfunction

endpackage

// File: rtl/bbk_decode.sv
`timescale 1ns/1ps
module bbk_decode #(
  parameter int RAM_AW = 7,
  parameter int N_RAM  = 4
) (
  input  logic [$clog2(N_RAM):0] hi_bits,   // [top] = group bit, rest = bank number
  output logic [N_RAM-1:0]       ram_cs_hi,
  output logic                   ram_cs_lo_n,
  output logic                   rom_cs_hi,
  output logic                   rom_cs_lo_n
);
  localparam int SEL_W = $clog2(N_RAM);

  logic [SEL_W-1:0] bank_no;
  logic             grp_bit;

  assign bank_no = hi_bits[SEL_W-1:0];
  assign grp_bit = hi_bits[SEL_W];

  // one-hot bank decoder feeds the active-high selects
  for (genvar i = 0; i < N_RAM; i++) begin : g_dec
    assign ram_cs_hi[i] = (bank_no == SEL_W'(i));
  end

  // group bit gates the RAM active-low selects and enables the ROM
  assign ram_cs_lo_n = grp_bit;
  assign rom_cs_hi   = grp_bit;
  assign rom_cs_lo_n = 1'b0;

endmodule

// File: rtl/bbk_ram_bank.sv
`timescale 1ns/1ps
module bbk_ram_bank #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_hi,
  input  logic          sel_lo_n,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          drive
);
  import bbk_pkg::*;

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] q_r;
  logic          vld_r;
  acc_e          kind;

  assign kind = access_kind(sel_hi, sel_lo_n, rd, wr);

  // storage array kept free of reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (kind == ACC_WR) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r   <= '0;
      vld_r <= 1'b0;
    end else begin
      vld_r <= (kind == ACC_RD);
      if (kind == ACC_RD) q_r <= mem[addr];
    end
  end

  assign rdata = vld_r ? q_r : '0;
  assign drive = vld_r;

endmodule

// File: rtl/bbk_rom_bank.sv
`timescale 1ns/1ps
module bbk_rom_bank #(
  parameter int          DW      = 8,
  parameter int          AW      = 9,
  parameter int unsigned IMG_MUL = 29,
  parameter int unsigned IMG_ADD = 91
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_hi,
  input  logic          sel_lo_n,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rdata,
  output logic          drive
);
  import bbk_pkg::*;

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] rom_mem [DEPTH];
  logic [DW-1:0] q_r;
  logic          vld_r;
  acc_e          kind;

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      rom_mem[k] = DW'(rom_word(k, IMG_MUL, IMG_ADD));
    end
  end

  assign kind = access_kind(sel_hi, sel_lo_n, rd, wr);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r   <= '0;
      vld_r <= 1'b0;
    end else begin
      vld_r <= (kind == ACC_RD);
      if (kind == ACC_RD) q_r <= rom_mem[addr];
    end
  end

  assign rdata = vld_r ? q_r : '0;
  assign drive = vld_r;

endmodule

// File: rtl/bytebank_top.sv
`timescale 1ns/1ps
module bytebank_top #(
  parameter int          BUS_AW  = 16,
  parameter int          DW      = 8,
  parameter int          RAM_AW  = 7,
  parameter int          N_RAM   = 4,
  parameter int unsigned IMG_MUL = 29,
  parameter int unsigned IMG_ADD = 91
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_drive
);
  localparam int SEL_W   = $clog2(N_RAM);
  localparam int GRP_BIT = RAM_AW + SEL_W;   // RAM/ROM split bit
  localparam int ROM_AW  = GRP_BIT;          // ROM covers the upper half

  logic [N_RAM-1:0] ram_cs_hi;
  logic             ram_cs_lo_n;
  logic             rom_cs_hi;
  logic             rom_cs_lo_n;

  logic [DW-1:0]    ram_q   [N_RAM];
  logic [N_RAM-1:0] ram_drv;
  logic [DW-1:0]    rom_q;
  logic             rom_drv;

  logic             unused_hi_addr;
  assign unused_hi_addr = ^bus_addr[BUS_AW-1:GRP_BIT+1];

  bbk_decode #(.RAM_AW(RAM_AW), .N_RAM(N_RAM)) u_dec (
    .hi_bits     (bus_addr[GRP_BIT:RAM_AW]),
    .ram_cs_hi   (ram_cs_hi),
    .ram_cs_lo_n (ram_cs_lo_n),
    .rom_cs_hi   (rom_cs_hi),
    .rom_cs_lo_n (rom_cs_lo_n)
  );

  for (genvar i = 0; i < N_RAM; i++) begin : g_ram
    bbk_ram_bank #(.DW(DW), .AW(RAM_AW)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .sel_hi   (ram_cs_hi[i]),
      .sel_lo_n (ram_cs_lo_n),
      .rd       (bus_rd),
      .wr       (bus_wr),
      .addr     (bus_addr[RAM_AW-1:0]),
      .wdata    (bus_wdata),
      .rdata    (ram_q[i]),
      .drive    (ram_drv[i])
    );
  end

  bbk_rom_bank #(.DW(DW), .AW(ROM_AW), .IMG_MUL(IMG_MUL), .IMG_ADD(IMG_ADD)) u_rom (
    .clk      (clk),
    .rst      (rst),
    .sel_hi   (rom_cs_hi),
    .sel_lo_n (rom_cs_lo_n),
    .rd       (bus_rd),
    .wr       (bus_wr),
    .addr     (bus_addr[ROM_AW-1:0]),
    .rdata    (rom_q),
    .drive    (rom_drv)
  );

  // banks hold zero when idle, so an OR acts as the shared bus
  always_comb begin
    bus_rdata = rom_q;
    bus_drive = rom_drv;
    for (int i = 0; i < N_RAM; i++) begin
      bus_rdata = bus_rdata | ram_q[i];
      bus_drive = bus_drive | ram_drv[i];
    end
  end

endmodule

// File: rtl/bbk_checker.sv
`timescale 1ns/1ps
module bbk_checker #(
  parameter int BUS_AW = 16,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DW-1:0]     bus_rdata,
  input logic              bus_drive
);
  logic unused_chk;
  assign unused_chk = ^bus_addr;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!bus_drive && bus_rdata == '0));

  // R3
  read_drives_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr) |=> bus_drive);

  // R7
  clash_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_wr) |=> !bus_drive);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd && !bus_wr) |=> !bus_drive);

  // R2
  write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd) |=> !bus_drive);

  // R10
  zero_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_drive |-> bus_rdata == '0);

endmodule

bind bytebank_top bbk_checker #(.BUS_AW(BUS_AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .bus_drive (bus_drive)
);

// File: tb/sim_bytebank_top.sv
`timescale 1ns/1ps
module sim_bytebank_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_drive;

  int checks = 0;
  int errors = 0;

  logic [7:0] q_d [$];
  logic       q_v [$];
  string      q_tag [$];

  logic [7:0] ram_m [512];   // bench model of the RAM banks, flat by addr[8:0]

  always #4 clk = ~clk;      // 125 MHz

  bytebank_top u0 (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_drive (bus_drive)
  );

  function automatic logic [7:0] rom_ref(input int k);
    return 8'((k * 29 + 91) ^ (k >> 1));
  endfunction

  // one bus cycle: drive at the falling edge, expect the result after the next rising edge
  task automatic cyc(input logic [15:0] a, input logic rd, input logic wr,
                     input logic [7:0] wd, input logic [7:0] ed, input logic ev,
                     input string tag);
    @(negedge clk);
    bus_addr  = a;
    bus_rd    = rd;
    bus_wr    = wr;
    bus_wdata = wd;
    q_d.push_back(ed);
    q_v.push_back(ev);
    q_tag.push_back(tag);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string tag);
    if (!a[9]) ram_m[a[8:0]] = d;
    cyc(a, 1'b0, 1'b1, d, 8'h00, 1'b0, tag);
  endtask

  task automatic do_read(input logic [15:0] a, input string tag);
    logic [7:0] e;
    e = a[9] ? rom_ref(int'(a[8:0])) : ram_m[a[8:0]];
    cyc(a, 1'b1, 1'b0, 8'h00, e, 1'b1, tag);
  endtask

  task automatic do_idle(input string tag);
    cyc(16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, tag);
  endtask

  // monitor: pop one expected item per cycle and compare
  logic [7:0] m_d;
  logic       m_v;
  string      m_tag;
  always @(posedge clk) begin
    #2;
    if (q_v.size() > 0) begin
      m_d   = q_d.pop_front();
      m_v   = q_v.pop_front();
      m_tag = q_tag.pop_front();
      checks++;
      if (bus_drive !== m_v || bus_rdata !== m_d) begin
        errors++;
        $display("FAIL %s: drive=%0b data=%02h expected drive=%0b data=%02h",
                 m_tag, bus_drive, bus_rdata, m_v, m_d);
      end
    end
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset dominates a pending ROM read
    bus_addr = 16'h0200;
    bus_rd   = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (bus_drive !== 1'b0 || bus_rdata !== 8'h00) begin
      errors++;
      $display("FAIL R1: drive=%0b data=%02h expected drive=0 data=00", bus_drive, bus_rdata);
    end
    bus_rd = 1'b0;
    rst    = 1'b0;

    // R8 idle
    do_idle("R8");
    do_idle("R10");

    // R2/R4: same offset in every bank, plus edge offsets
    do_write(16'h0005, 8'hA1, "R2");
    do_write(16'h0085, 8'hB2, "R2");
    do_write(16'h0105, 8'hC3, "R2");
    do_write(16'h0185, 8'hD4, "R2");
    do_write(16'h007F, 8'h5E, "R2");
    do_write(16'h0180, 8'h77, "R2");
    do_read(16'h0005, "R4");
    do_read(16'h0085, "R4");
    do_read(16'h0105, "R4");
    do_read(16'h0185, "R4");
    do_read(16'h007F, "R3");
    do_read(16'h0180, "R3");
    do_idle("R10");

    // R5: ROM corners
    do_read(16'h0200, "R5");
    do_read(16'h02FF, "R5");
    do_read(16'h0305, "R5");
    do_read(16'h03FF, "R5");

    // R6: write into the ROM range is dropped
    do_write(16'h0205, 8'hEE, "R6");
    do_write(16'h0385, 8'hEE, "R6");
    do_read(16'h0005, "R6");
    do_read(16'h0185, "R6");
    do_read(16'h0205, "R6");
    do_read(16'h0385, "R6");

    // R7: both strobes high, no store and no drive
    cyc(16'h0085, 1'b1, 1'b1, 8'h11, 8'h00, 1'b0, "R7");
    cyc(16'h0300, 1'b1, 1'b1, 8'h11, 8'h00, 1'b0, "R7");
    do_read(16'h0085, "R7");

    // R9: upper address bits ignored
    do_write(16'hFC05, 8'h3C, "R9");
    do_read(16'h0005, "R9");
    do_read(16'hA7FF, "R9");
    do_read(16'h5585, "R9");

    // R4: every offset of bank 2 holds its own byte
    for (int k = 0; k < 128; k++) do_write(16'(16'h0100 + k), 8'(k * 3 + 1), "R4");
    for (int k = 0; k < 128; k++) do_read(16'(16'h0100 + k), "R4");
    do_read(16'h0085, "R4");
    do_idle("R8");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule